// File: doc/BRIEF.md
# Descriptor-Chained Stream-to-Memory Engine

This engine takes a word stream from a client, with a marker on the last word of each packet, and writes it into memory buffers. A chain of linked data descriptors in memory describes those buffers. Each data descriptor is four words: next-descriptor address, buffer start, flags and buffer end. A descriptor closes when its buffer is full or when a packet ends, whichever comes first. On closing, the engine writes two fields back into the descriptor. The end field becomes the real fill point, and the flags gain a packet-end bit when a packet ended there. The engine then either loads the next descriptor or, at the end of the list, marks the channel's context descriptor as disabled and stops taking input.

Software or a sequencer starts the engine with a pulse carrying the first descriptor address and the context descriptor address. Completions set raw interrupt bits, which an acknowledge vector clears. Memory is word addressed, and every stream beat is one word. The memory port is registered and returns read data one cycle after a read is issued.

Top module: `dmain_engine`

## Requirements
- R1: After reset, `in_ready`, `eol`, `mem_en`, `intr_pulse` are low and `raw_intr` is 0.
- R2: On `start` the engine reads descriptor words at offsets 0 (next), 1 (buffer start), 2 (flags), 3 (end), then raises `in_ready` and writes accepted words to consecutive addresses from the buffer start.
- R3: A descriptor closes by filling when the write pointer reaches the end field. The end word (offset 3) is then rewritten with that same value, and the flags word is written back unchanged.
- R4: A beat with `in_last` closes the descriptor early. Offset 3 gets the address just past the last written word, and the flags word gets bit 12 set.
- R5: If flags bit 4 is set, closing the descriptor sets `raw_intr` bits 0 and 1 on the clock edge after the closing beat.
- R6: Closing on `in_last` sets `raw_intr` bit 3 on the clock edge after the closing beat.
- R7: `intr_pulse` is high for one cycle exactly when `raw_intr` has just changed value. A completion that sets bits that are already set gives no pulse.
- R8: A bit set in `intr_ack` clears that `raw_intr` bit on the next edge, unless the same bit is being set in that cycle.
- R9: When flags bit 0 (end of list) is clear, the engine follows the next field, restarts the pointer at that descriptor's buffer start, and continues an unfinished packet there.
- R10: When flags bit 0 is set, the engine reads the context word at `ctx_desc` and writes it back with bit 16 set. At that same edge it raises `eol`. From then on `in_ready` stays low and stream input causes no memory write.
- R11: A `start` while stopped at end of list clears `eol` and runs a new chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, honoured when idle or stopped |
| first_desc | input | AW | Address of first data descriptor |
| ctx_desc | input | AW | Address of context descriptor word |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Engine accepts a stream word |
| in_data | input | DW | Stream word |
| in_last | input | 1 | Last word of a packet |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |
| intr_ack | input | 4 | Clear mask for raw interrupt bits |
| raw_intr | output | 4 | Raw interrupt bits |
| intr_pulse | output | 1 | Raw interrupt value just changed |
| eol | output | 1 | Stopped at end of list |

## Verification
Call E the edge that accepts the closing beat. The raw interrupt bits and the change pulse become visible just after edge E+1. The flags write lands in memory at E+2 and the end-field write at E+3. A descriptor load takes six cycles from `start` or from the previous write-back. The interrupt checks therefore sample at the falling edge that follows E+1. Every memory-content check waits first for `eol` or for `in_ready`, so it never samples before the write it depends on. The ignored-input check counts memory writes across a window in which valid is held high after end of list.

// File: rtl/dmain_pkg.sv
package dmain_pkg;
  // descriptor word offsets
  localparam int W_NEXT  = 0;
  localparam int W_BUF   = 1;
  localparam int W_FLAGS = 2;
  localparam int W_AFTER = 3;
  localparam int DESC_WORDS = 4;
  // flag bit positions
  localparam int F_EOL   = 0;
  localparam int F_INTR  = 4;
  localparam int F_INEOP = 12;
  localparam int CTX_DIS = 16;
  // raw interrupt bits
  localparam int IRQ_W   = 4;
  localparam int IRQ_EOP = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_STREAM, S_WB_FLAGS, S_WB_AFTER,
    S_CTX_RD, S_CTX_WAIT, S_CTX_WR, S_HALT
  } st_t;
endpackage

// File: rtl/dmain_desc.sv
module dmain_desc #(
  parameter int DW = 32,
  parameter int NW = 4,
  localparam int IW = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [IW-1:0]    cap_idx,
  input  logic [DW-1:0]    rdata,
  output logic [NW*DW-1:0] words
);
  for (genvar i = 0; i < NW; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[i*DW +: DW] <= '0;
      else if (cap_en && cap_idx == IW'(i))
        words[i*DW +: DW] <= rdata;
    end
  end
endmodule

// File: rtl/dmain_irq.sv
module dmain_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] ack_vec,
  output logic [N-1:0] raw,
  output logic         pulse
);
  logic [N-1:0] nxt;
  assign nxt = (raw & ~ack_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw   <= '0;
      pulse <= 1'b0;
    end else begin
      raw   <= nxt;
      pulse <= (nxt != raw);
    end
  end

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (|(ack_vec & ~set_vec)) |=> ((raw & $past(ack_vec & ~set_vec)) == '0));
  // R7
  pulse_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    ##1 (pulse == (raw != $past(raw))));
endmodule

// File: rtl/dmain_engine.sv
module dmain_engine
  import dmain_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     first_desc,
  input  logic [AW-1:0]     ctx_desc,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic              in_last,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [IRQ_W-1:0]  intr_ack,
  output logic [IRQ_W-1:0]  raw_intr,
  output logic              intr_pulse,
  output logic              eol
);
  localparam int CW = 3;
  localparam int LAT = 2; // issue register + memory read register
  localparam logic [CW-1:0] LOAD_LAST = CW'(DESC_WORDS + LAT - 1);

  st_t              state;
  logic [AW-1:0]    desc_q, ctx_q, ptr_q, ptr_inc;
  logic [CW-1:0]    cnt_q;
  logic             eop_q, beat, fill_done, cap_en;
  logic [DESC_WORDS*DW-1:0] words;
  logic [DW-1:0]    next_w, buf_w, flags_w, after_w;
  logic [IRQ_W-1:0] set_vec;

  assign next_w  = words[W_NEXT*DW  +: DW];
  assign buf_w   = words[W_BUF*DW   +: DW];
  assign flags_w = words[W_FLAGS*DW +: DW];
  assign after_w = words[W_AFTER*DW +: DW];

  assign in_ready  = (state == S_STREAM);
  assign beat      = in_valid && in_ready;
  assign ptr_inc   = ptr_q + AW'(1);
  assign fill_done = (ptr_inc == AW'(after_w));
  assign cap_en    = (state == S_LOAD) && (cnt_q >= CW'(LAT));

  always_comb begin
    set_vec = '0;
    if (state == S_WB_FLAGS) begin
      set_vec[0]       = flags_w[F_INTR];
      set_vec[1]       = flags_w[F_INTR];
      set_vec[IRQ_EOP] = eop_q;
    end
  end

  dmain_desc #(.DW(DW), .NW(DESC_WORDS)) u_desc (
    .clk(clk), .rst(rst), .cap_en(cap_en),
    .cap_idx(2'(cnt_q - CW'(LAT))), .rdata(mem_rdata), .words(words)
  );

  dmain_irq #(.N(IRQ_W)) u_irq (
    .clk(clk), .rst(rst), .set_vec(set_vec), .ack_vec(intr_ack),
    .raw(raw_intr), .pulse(intr_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      desc_q    <= '0;
      ctx_q     <= '0;
      ptr_q     <= '0;
      cnt_q     <= '0;
      eop_q     <= 1'b0;
      eol       <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      unique case (state)
        S_IDLE, S_HALT: begin
          if (start) begin
            desc_q <= first_desc;
            ctx_q  <= ctx_desc;
            cnt_q  <= '0;
            eol    <= 1'b0;
            state  <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (cnt_q < CW'(DESC_WORDS)) begin
            mem_en   <= 1'b1;
            mem_addr <= desc_q + AW'(cnt_q);
          end
          if (cnt_q == LOAD_LAST) begin
            ptr_q <= AW'(buf_w);
            state <= S_STREAM;
          end
          cnt_q <= cnt_q + CW'(1);
        end
        S_STREAM: begin
          if (beat) begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= ptr_q;
            mem_wdata <= in_data;
            ptr_q     <= ptr_inc;
            if (fill_done || in_last) begin
              eop_q <= in_last;
              state <= S_WB_FLAGS;
            end
          end
        end
        S_WB_FLAGS: begin
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= desc_q + AW'(W_FLAGS);
          mem_wdata <= flags_w | (DW'(eop_q) << F_INEOP);
          state     <= S_WB_AFTER;
        end
        S_WB_AFTER: begin
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= desc_q + AW'(W_AFTER);
          mem_wdata <= DW'(ptr_q);
          if (flags_w[F_EOL]) begin
            state <= S_CTX_RD;
          end else begin
            desc_q <= AW'(next_w);
            cnt_q  <= '0;
            state  <= S_LOAD;
          end
        end
        S_CTX_RD: begin
          mem_en   <= 1'b1;
          mem_addr <= ctx_q;
          state    <= S_CTX_WAIT;
        end
        S_CTX_WAIT: state <= S_CTX_WR;
        S_CTX_WR: begin
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= ctx_q;
          mem_wdata <= mem_rdata | (DW'(1) << CTX_DIS);
          eol       <= 1'b1;
          state     <= S_HALT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  eol_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    eol |-> !in_ready);
  // R10
  ctx_disable_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eol) |-> (mem_we && mem_en && mem_wdata[CTX_DIS]));
  // R3
  ptr_below_end_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (ptr_q != AW'(after_w)));
  // R2
  load_reads_only_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOAD) |=> !mem_we);
endmodule

// File: tb/dmain_engine_bench.sv
module dmain_engine_bench;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] first_desc = '0, ctx_desc = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, mem_en, mem_we, intr_pulse, eol;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [3:0] intr_ack = '0, raw_intr;

  logic [DW-1:0] mem [0:255];
  int wr_cnt = 0;
  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk; // 125 MHz

  dmain_engine #(.AW(AW), .DW(DW)) u_dmain_engine (
    .clk(clk), .rst(rst), .start(start), .first_desc(first_desc),
    .ctx_desc(ctx_desc), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .intr_ack(intr_ack), .raw_intr(raw_intr), .intr_pulse(intr_pulse),
    .eol(eol)
  );

  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end else if (mem_en) begin
      mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      fails = fails + 1;
      $display("FAIL watchdog R1: actual cycles=%0d expected<50000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] nx, input logic [31:0] bf,
                          input logic [31:0] fl, input logic [31:0] af);
    mem[a] = nx; mem[a+1] = bf; mem[a+2] = fl; mem[a+3] = af;
  endtask

  task automatic kick(input logic [31:0] d, input logic [31:0] c);
    @(negedge clk);
    first_desc = d; ctx_desc = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic [31:0] d, input bit last);
    int t = 0;
    @(negedge clk);
    while (!in_ready && t < 200) begin @(negedge clk); t++; end
    in_valid = 1'b1; in_data = d; in_last = last;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_eol();
    int t = 0;
    while (!eol && t < 200) begin @(negedge clk); t++; end
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!in_ready && !eol && !mem_en && !intr_pulse, "R1 ctrl",
        {in_ready, eol, mem_en, intr_pulse}, 0);
    chk(raw_intr == 0, "R1 raw_intr", raw_intr, 0);
  endtask

  task automatic t_chain();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    put_desc(8'h10, 32'h20, 32'h80, 32'h10, 32'h84);
    put_desc(8'h20, 32'h30, 32'h90, 32'h01, 32'h98);
    mem[8'h08] = 32'h5;
    kick(32'h10, 32'h08);
    for (int i = 0; i < 4; i++) send(32'hA0 + i, 1'b0);
    chk(!in_ready, "R3 closed by fill", in_ready, 0);
    @(posedge clk); @(negedge clk);
    chk(raw_intr == 4'h3, "R5 intr bits", raw_intr, 4'h3);
    chk(intr_pulse, "R7 pulse on change", intr_pulse, 1);
    send(32'hA4, 1'b0);
    send(32'hA5, 1'b1);
    @(posedge clk); @(negedge clk);
    chk(raw_intr == 4'hB, "R6 eop bit", raw_intr, 4'hB);
    chk(intr_pulse, "R7 pulse eop", intr_pulse, 1);
    wait_eol();
    for (int i = 0; i < 4; i++)
      chk(mem[8'h80 + i] == 32'hA0 + i, "R2 data", mem[8'h80 + i], 32'hA0 + i);
    chk(mem[8'h13] == 32'h84, "R3 end word", mem[8'h13], 32'h84);
    chk(mem[8'h12] == 32'h10, "R3 flags unchanged", mem[8'h12], 32'h10);
    chk(mem[8'h90] == 32'hA4 && mem[8'h91] == 32'hA5, "R9 continue",
        mem[8'h91], 32'hA5);
    chk(mem[8'h23] == 32'h92, "R4 end rewritten", mem[8'h23], 32'h92);
    chk(mem[8'h22] == 32'h1001, "R4 eop flag", mem[8'h22], 32'h1001);
    chk(mem[8'h08] == 32'h10005, "R10 ctx disable", mem[8'h08], 32'h10005);
    chk(eol && !in_ready, "R10 stopped", {eol, in_ready}, 2'b10);
  endtask

  task automatic t_ignore();
    int w0 = wr_cnt;
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'hBAD; in_last = 1'b1;
    repeat (10) @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    chk(wr_cnt == w0, "R10 no write after eol", wr_cnt, w0);
    chk(mem[8'h92] == 0 && !in_ready, "R10 input ignored", mem[8'h92], 0);
  endtask

  task automatic t_ack();
    @(negedge clk); intr_ack = 4'h3;
    @(negedge clk); intr_ack = 4'h0;
    chk(raw_intr == 4'h8, "R8 partial ack", raw_intr, 4'h8);
    @(negedge clk); intr_ack = 4'h8;
    @(negedge clk); intr_ack = 4'h0;
    chk(raw_intr == 4'h0, "R8 full ack", raw_intr, 0);
  endtask

  task automatic t_restart();
    put_desc(8'h40, 32'h50, 32'hA0, 32'h10, 32'hA2);
    put_desc(8'h50, 32'h00, 32'hB0, 32'h11, 32'hB2);
    mem[8'h09] = 32'h0;
    kick(32'h40, 32'h09);
    chk(!eol, "R11 eol cleared", eol, 0);
    send(32'hC0, 1'b0);
    send(32'hC1, 1'b0);
    @(posedge clk); @(negedge clk);
    chk(raw_intr == 4'h3 && intr_pulse, "R5 second chain", raw_intr, 4'h3);
    send(32'hC2, 1'b0);
    send(32'hC3, 1'b0);
    @(posedge clk); @(negedge clk);
    chk(raw_intr == 4'h3, "R7 raw held", raw_intr, 4'h3);
    chk(!intr_pulse, "R7 no pulse without change", intr_pulse, 0);
    wait_eol();
    chk(mem[8'h42] == 32'h10 && mem[8'h43] == 32'hA2, "R3 fill close",
        mem[8'h43], 32'hA2);
    chk(mem[8'hB1] == 32'hC3 && mem[8'h53] == 32'hB2, "R9 next buffer",
        mem[8'hB1], 32'hC3);
    chk(mem[8'h09] == 32'h10000 && eol, "R11 second stop", mem[8'h09], 32'h10000);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_chain();
    t_ignore();
    t_ack();
    t_restart();
    summary();
    $finish;
  end
endmodule